// File: doc/BRIEF.md
# Four-Lane Striped Vector Adder

This unit adds two vector registers element by element and writes the sums into a third. The register file is divided among four lanes: element `i` of every register lives in lane `i % 4`, at slot `i / 4` of that lane's private slice. Each lane owns a pipelined integer adder and only reads and writes its own slice. Four neighbouring elements therefore start together, and one group of four sums leaves the lanes every clock once the pipeline is full.

An operation begins with a one-cycle `start` strobe that carries the vector length and the two source and one destination register numbers. `busy` is high while the operation runs. `done` pulses for one cycle when the last sums are in the register file. Element write and read ports let the surrounding logic fill and inspect the registers. Both ports take a register number and an element index.

Top module: `vec_lane_adder`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every element of every register reads as 0.
- R2: A write with `ldEn` high and `busy` low stores `ldData` into element `ldIdx` of register `ldReg` at the next rising edge. `rdData` shows element `rdIdx` of register `rdReg` combinationally.
- R3: For every index `i` below the length, the destination element `i` becomes `(A[i] + B[i]) mod 2^32`.
- R4: Destination elements at indices at or above the length are not changed. This includes the idle lanes of a partial final group of four.
- R5: Let E0 be the edge that accepts `start` and let `G = ceil(len/4)`. Then `done` is high only in the cycle after edge E(G+3), as a single-cycle pulse, and all results are readable in that cycle.
- R6: `busy` rises at E0, stays high through the cycle before edge E(G+3), and falls at the edge where `done` rises.
- R7: A `start` while `busy` is high is ignored. The operation in flight keeps its results and timing, and the register named by the second strobe is left untouched.
- R8: A `start` whose length is 0 or greater than 32 is ignored: `busy` stays low and no register changes.
- R9: Element writes presented while `busy` is high are ignored.
- R10: The destination may be the same register as a source, and the result is still the element-wise sum of the original operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation request strobe |
| vecLen | input | 6 | Number of elements, valid range 1..32 |
| srcA | input | 3 | First source register |
| srcB | input | 3 | Second source register |
| dst | input | 3 | Destination register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ldEn | input | 1 | Element write enable |
| ldReg | input | 3 | Register for element write |
| ldIdx | input | 5 | Element index for element write |
| ldData | input | 32 | Element write data |
| rdReg | input | 3 | Register for element read |
| rdIdx | input | 5 | Element index for element read |
| rdData | output | 32 | Element read data, combinational |

## Verification
Every run is timed from the edge that accepts `start`. The bench computes `G = ceil(len/4)` and samples `busy` and `done` at each falling edge after edges E1 through E(G+3). It expects `busy` high up to E(G+2) and `done` high only after E(G+3). After that it samples one more cycle to confirm that `done` has dropped. Register contents are read back only after `done`, through the combinational read port, one time unit after a falling edge, and compared with a model the bench keeps itself. The tests cover lengths of 1, 7 and 32 so that the group count, and with it the completion cycle, differs between them.

// File: rtl/vla_pkg.sv
package vla_pkg;
  localparam int LANES  = 4;
  localparam int NREGS  = 8;
  localparam int MAXLEN = 32;
  localparam int EW     = 32;
  localparam int PIPE   = 3;

  localparam int SLOTS  = MAXLEN / LANES;
  localparam int REG_W  = $clog2(NREGS);
  localparam int LANE_W = $clog2(LANES);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int IDX_W  = $clog2(MAXLEN);
  localparam int LEN_W  = $clog2(MAXLEN + 1);

  // strobes from control to datapath
  typedef struct packed {
    logic              issue;
    logic [SLOT_W-1:0] grp;
    logic [LANES-1:0]  laneMask;
    logic [REG_W-1:0]  srcA;
    logic [REG_W-1:0]  srcB;
    logic [REG_W-1:0]  dst;
    logic              hostLock;
  } ctl_t;
endpackage

// File: rtl/vla_lane.sv
module vla_lane
  import vla_pkg::*;
#(
  parameter int LANE_ID = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic              ldHit,
  input  logic [REG_W-1:0]  ldReg,
  input  logic [SLOT_W-1:0] ldSlot,
  input  logic [EW-1:0]     ldData,
  input  logic [REG_W-1:0]  rdReg,
  input  logic [SLOT_W-1:0] rdSlot,
  output logic [EW-1:0]     rdData
);
  logic [EW-1:0]     rf [NREGS][SLOTS];
  logic [PIPE-1:0]   vld;
  logic [SLOT_W-1:0] slotP [PIPE];
  logic [EW-1:0]     opA, opB;
  logic [EW-1:0]     sumP [1:PIPE-1];
  logic              act;

  assign act    = ctl.issue && ctl.laneMask[LANE_ID];
  assign rdData = rf[rdReg][rdSlot];

  // adder pipeline: operand capture, add, then delay stages
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld <= '0;
      opA <= '0;
      opB <= '0;
      for (int i = 0; i < PIPE; i++) slotP[i] <= '0;
      for (int i = 1; i < PIPE; i++) sumP[i] <= '0;
    end else begin
      vld      <= {vld[PIPE-2:0], act};
      opA      <= rf[ctl.srcA][ctl.grp];
      opB      <= rf[ctl.srcB][ctl.grp];
      slotP[0] <= ctl.grp;
      sumP[1]  <= opA + opB;
      for (int i = 1; i < PIPE; i++) slotP[i] <= slotP[i-1];
      for (int i = 2; i < PIPE; i++) sumP[i] <= sumP[i-1];
    end
  end

  // private register slice: pipeline writeback wins, host writes only when idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NREGS; r++)
        for (int s = 0; s < SLOTS; s++) rf[r][s] <= '0;
    end else if (vld[PIPE-1]) begin
      rf[ctl.dst][slotP[PIPE-1]] <= sumP[PIPE-1];
    end else if (ldHit && !ctl.hostLock) begin
      rf[ldReg][ldSlot] <= ldData;
    end
  end
endmodule

// File: rtl/vla_datapath.sv
module vla_datapath
  import vla_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctl_t             ctl,
  input  logic             ldEn,
  input  logic [REG_W-1:0] ldReg,
  input  logic [IDX_W-1:0] ldIdx,
  input  logic [EW-1:0]    ldData,
  input  logic [REG_W-1:0] rdReg,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [EW-1:0]    rdData
);
  logic [EW-1:0] laneRd [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic hit;
    assign hit = ldEn && (ldIdx[LANE_W-1:0] == LANE_W'(l));
    vla_lane #(.LANE_ID(l)) u_lane (
      .clk    (clk),
      .rstN   (rstN),
      .ctl    (ctl),
      .ldHit  (hit),
      .ldReg  (ldReg),
      .ldSlot (ldIdx[IDX_W-1:LANE_W]),
      .ldData (ldData),
      .rdReg  (rdReg),
      .rdSlot (rdIdx[IDX_W-1:LANE_W]),
      .rdData (laneRd[l])
    );
  end

  assign rdData = laneRd[rdIdx[LANE_W-1:0]];
endmodule

// File: rtl/vla_ctrl.sv
module vla_ctrl
  import vla_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] vecLen,
  input  logic [REG_W-1:0] srcA,
  input  logic [REG_W-1:0] srcB,
  input  logic [REG_W-1:0] dst,
  output ctl_t             ctl,
  output logic             busy,
  output logic             done
);
  logic              busyR, doneR, issuing;
  logic [SLOT_W-1:0] grp;
  logic [LEN_W-1:0]  lenR;
  logic [REG_W-1:0]  srcAR, srcBR, dstR;
  logic [PIPE-1:0]   lastPipe;
  logic              accept, lastGrp;
  logic [LEN_W-1:0]  lenM1;
  logic [LANES-1:0]  mask;

  assign accept  = start && !busyR && (vecLen != '0) && (int'(vecLen) <= MAXLEN);
  assign lenM1   = lenR - LEN_W'(1);
  assign lastGrp = (grp == SLOT_W'(lenM1 >> LANE_W));

  always_comb begin
    for (int l = 0; l < LANES; l++)
      mask[l] = (int'(grp) * LANES + l) < int'(lenR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyR    <= 1'b0;
      doneR    <= 1'b0;
      issuing  <= 1'b0;
      grp      <= '0;
      lenR     <= '0;
      srcAR    <= '0;
      srcBR    <= '0;
      dstR     <= '0;
      lastPipe <= '0;
    end else begin
      doneR    <= 1'b0;
      lastPipe <= {lastPipe[PIPE-2:0], issuing && lastGrp};
      if (accept) begin
        busyR   <= 1'b1;
        issuing <= 1'b1;
        grp     <= '0;
        lenR    <= vecLen;
        srcAR   <= srcA;
        srcBR   <= srcB;
        dstR    <= dst;
      end else begin
        if (issuing) begin
          if (lastGrp) issuing <= 1'b0;
          else         grp     <= grp + SLOT_W'(1);
        end
        if (lastPipe[PIPE-1]) begin
          busyR <= 1'b0;
          doneR <= 1'b1;
        end
      end
    end
  end

  assign ctl.issue    = issuing;
  assign ctl.grp      = grp;
  assign ctl.laneMask = mask;
  assign ctl.srcA     = srcAR;
  assign ctl.srcB     = srcBR;
  assign ctl.dst      = dstR;
  assign ctl.hostLock = busyR;
  assign busy         = busyR;
  assign done         = doneR;
endmodule

// File: rtl/vec_lane_adder.sv
module vec_lane_adder
  import vla_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] vecLen,
  input  logic [REG_W-1:0] srcA,
  input  logic [REG_W-1:0] srcB,
  input  logic [REG_W-1:0] dst,
  output logic             busy,
  output logic             done,
  input  logic             ldEn,
  input  logic [REG_W-1:0] ldReg,
  input  logic [IDX_W-1:0] ldIdx,
  input  logic [EW-1:0]    ldData,
  input  logic [REG_W-1:0] rdReg,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [EW-1:0]    rdData
);
  ctl_t ctlBus;

  vla_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .vecLen (vecLen),
    .srcA   (srcA),
    .srcB   (srcB),
    .dst    (dst),
    .ctl    (ctlBus),
    .busy   (busy),
    .done   (done)
  );

  vla_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctlBus),
    .ldEn   (ldEn),
    .ldReg  (ldReg),
    .ldIdx  (ldIdx),
    .ldData (ldData),
    .rdReg  (rdReg),
    .rdIdx  (rdIdx),
    .rdData (rdData)
  );
endmodule

// File: rtl/vla_checker.sv
module vla_checker
  import vla_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [LEN_W-1:0] vecLen,
  input logic             busy,
  input logic             done,
  input logic             issue,
  input logic [LANES-1:0] laneMask,
  input logic             hostLock
);
  logic       okStart;
  logic [7:0] cnt;
  logic [LEN_W-1:0] lenL;
  int         dueCnt;

  assign okStart = start && !busy && (vecLen != '0) && (int'(vecLen) <= MAXLEN);
  assign dueCnt  = (int'(lenL) + LANES - 1) / LANES + PIPE;

  // independent cycle counter for the latency window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      lenL <= '0;
    end else if (okStart) begin
      cnt  <= '0;
      lenL <= vecLen;
    end else if (busy) begin
      cnt <= cnt + 8'd1;
    end
  end

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (int'(cnt) == dueCnt));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_busy_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_busy_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  assert_restart_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy) |=> (!busy || (cnt == $past(cnt) + 8'd1)));

  assert_bad_len_R8: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && (vecLen == '0 || int'(vecLen) > MAXLEN)) |=> !busy);

  assert_mask_shape_R4: assert property (@(posedge clk) disable iff (!rstN)
    issue |-> (laneMask[0] && ((laneMask & (laneMask + 1'b1)) == '0)));

  assert_lock_R9: assert property (@(posedge clk) disable iff (!rstN)
    issue |-> (busy && hostLock));
endmodule

bind vec_lane_adder vla_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .vecLen   (vecLen),
  .busy     (busy),
  .done     (done),
  .issue    (ctlBus.issue),
  .laneMask (ctlBus.laneMask),
  .hostLock (ctlBus.hostLock)
);

// File: tb/tb_vec_lane_adder.sv
`timescale 1ns/1ps
module tb_vec_lane_adder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  vecLen = '0;
  logic [2:0]  srcA = '0, srcB = '0, dst = '0;
  logic        busy, done;
  logic        ldEn = 1'b0;
  logic [2:0]  ldReg = '0;
  logic [4:0]  ldIdx = '0;
  logic [31:0] ldData = '0;
  logic [2:0]  rdReg = '0;
  logic [4:0]  rdIdx = '0;
  logic [31:0] rdData;

  int total = 0;
  int bad = 0;
  logic [31:0] model [8][32];

  vec_lane_adder dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readEl(input int r, input int i, output logic [31:0] v);
    rdReg = 3'(r);
    rdIdx = 5'(i);
    #1;
    v = rdData;
  endtask

  task automatic checkReg(input int r, input string tag);
    logic [31:0] v;
    for (int i = 0; i < 32; i++) begin
      readEl(r, i, v);
      chk($sformatf("%s reg%0d[%0d]", tag, r, i), v, model[r][i]);
    end
  endtask

  task automatic loadVec(input int r, input logic [31:0] seed, input logic [31:0] step);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      ldEn   = 1'b1;
      ldReg  = 3'(r);
      ldIdx  = 5'(i);
      ldData = seed + step * 32'(i);
      model[r][i] = ldData;
    end
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  // run one add and check busy/done cycle by cycle; optional intrusions
  task automatic runOp(input int a, input int b, input int d, input int len,
                       input bit intrStart, input bit intrLoad, input string tag);
    int g;
    logic [31:0] res [32];
    g = (len + 3) / 4;
    for (int i = 0; i < 32; i++) res[i] = model[d][i];
    for (int i = 0; i < len; i++) res[i] = model[a][i] + model[b][i];
    @(negedge clk);
    start = 1'b1; vecLen = 6'(len);
    srcA = 3'(a); srcB = 3'(b); dst = 3'(d);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R6 busy after accept"}, 32'(busy), 32'd1);
    for (int k = 1; k <= g + 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      ldEn  = 1'b0;
      chk($sformatf("%s R5 done k=%0d", tag, k), 32'(done), 32'(k == g + 3));
      chk($sformatf("%s R6 busy k=%0d", tag, k), 32'(busy), 32'(k < g + 3));
      if (k == 1 && intrStart) begin
        start = 1'b1; vecLen = 6'd4; srcA = 3'd1; srcB = 3'd2; dst = 3'd6;
      end
      if (k == 1 && intrLoad) begin
        ldEn = 1'b1; ldReg = 3'd7; ldIdx = 5'd0; ldData = 32'hDEAD_BEEF;
      end
    end
    for (int i = 0; i < 32; i++) model[d][i] = res[i];
    checkReg(d, {tag, " R3 R4"});
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R5 done is a pulse"}, 32'(done), 32'd0);
  endtask

  task automatic testReset;
    logic [31:0] v;
    chk("R1 busy at reset", 32'(busy), 32'd0);
    chk("R1 done at reset", 32'(done), 32'd0);
    for (int r = 0; r < 8; r++) begin
      readEl(r, r * 4 + 3, v);
      chk($sformatf("R1 reg%0d zero", r), v, 32'd0);
    end
  endtask

  task automatic testLoad;
    loadVec(0, 32'hFFFF_FFF0, 32'h0000_0001);
    loadVec(1, 32'h0000_0020, 32'h1111_0003);
    loadVec(2, 32'h8000_0000, 32'hF000_0007);
    loadVec(5, 32'h1234_5678, 32'h0101_0101);
    loadVec(7, 32'hCAFE_0000, 32'h0000_0010);
    checkReg(0, "R2 load");
    checkReg(5, "R2 load");
  endtask

  task automatic testBadLen(input int len);
    @(negedge clk);
    start = 1'b1; vecLen = 6'(len); srcA = 3'd0; srcB = 3'd1; dst = 3'd5;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 6; k++) begin
      chk($sformatf("R8 busy len=%0d", len), 32'(busy), 32'd0);
      chk($sformatf("R8 done len=%0d", len), 32'(done), 32'd0);
      @(negedge clk);
    end
    checkReg(5, "R8 no write");
  endtask

  initial begin
    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 32; i++) model[r][i] = '0;
    #20;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLoad();
    runOp(0, 1, 3, 32, 1'b0, 1'b0, "full");
    runOp(1, 2, 4, 7, 1'b0, 1'b0, "partial");
    runOp(2, 0, 5, 1, 1'b0, 1'b0, "single");
    runOp(0, 2, 0, 13, 1'b0, 1'b0, "R10 inplace");
    runOp(1, 5, 3, 32, 1'b1, 1'b0, "R7 restart");
    checkReg(6, "R7 untouched");
    runOp(3, 4, 2, 20, 1'b0, 1'b1, "R9 busyload");
    checkReg(7, "R9 ignored");
    testBadLen(0);
    testBadLen(40);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule